// File: doc/BRIEF.md
# LCD Common-Row Scan and Serial Segment Feed

This block drives the time-multiplexed scan of a character LCD whose segment columns sit behind external shift-register drivers. Each row period has two parts. First the block fetches the row's pixel bits one column at a time from a pixel source. It puts each bit on a serial data line and pulses a shift clock for it. When the whole row has been sent, a one-cycle load strobe makes the segment drivers latch the row. At the same clock edge that ends the strobe, the one-hot common outputs move to that row.

Software chooses how many commons one frame scans: 16, 24, 32 or 48. This duty value is read only when a frame starts. Each time the scan comes back to the first common, a frame-alternation output toggles, so the panel sees an AC drive waveform. The pixel source uses a request/valid pair, and it may take any number of cycles to answer a request.

Top module: `lcd_row_scanner`

## Requirements
- R1: The rows per frame follow `duty_sel`: 2'b00 gives 16, 2'b01 gives 24, 2'b10 gives 32 and 2'b11 gives 48. Rows are numbered from 0 up to the count minus 1, and then the numbering wraps to 0.
- R2: `duty_sel` is sampled only at a frame start. A change made part way through a frame leaves that frame at its old row count, and the next frame uses the new count.
- R3: Exactly one bit of `com` is high at any time. Bit i stands for row i, and bits at or above the active row count stay low.
- R4: Each row sends exactly BITS_PER_ROW bits. Each bit begins with a one-cycle `pix_req` that carries the row on `pix_row` and the column on `pix_col`. Columns run from 0 upward.
- R5: `seg_data` carries the `pix_dat` value that arrived with `pix_vld` for the latest request. `seg_clk` is high for exactly one cycle per bit, and it goes high in the cycle after `pix_vld`.
- R6: While `pix_vld` stays low, the block waits for as many cycles as it takes. During the wait `seg_clk` stays low and no new request is issued.
- R7: After the last bit of a row, `seg_load` is high for one cycle. `seg_clk` is low during that cycle. `com` changes only at the edge that ends a load cycle, and it then shows the row that was just loaded.
- R8: `frame_ac` toggles exactly once per frame. It toggles at the edge where `com` moves back to row 0 from another row.
- R9: While `rst_n` is low, the outputs are: `com` = row 0, `frame_ac` = 0, and `seg_load`, `seg_clk`, `pix_req` and `seg_data` all 0. After reset, the scan starts again at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_sel | input | 2 | Duty select, sampled at frame start |
| pix_vld | input | 1 | Pixel source answer valid |
| pix_dat | input | 1 | Pixel bit for the pending request |
| pix_req | output | 1 | One-cycle pixel request |
| pix_row | output | ROW_W | Row of the requested pixel |
| pix_col | output | COL_W | Column of the requested pixel |
| seg_data | output | 1 | Serial data to segment drivers |
| seg_clk | output | 1 | Shift clock to segment drivers |
| seg_load | output | 1 | Row latch strobe |
| com | output | NUM_COMS | One-hot common select |
| frame_ac | output | 1 | Frame-alternation signal |

## Verification
The hardest case to reach from the ports is a duty change that lands inside a frame. The old row count must finish that frame, and the new count must take over at the next wrap. The stimulus changes `duty_sel` only just after row 1 has been loaded, so the change can never coincide with the frame-start sample. The bench then counts loads across the next two frame toggles. A slow pixel source, answering six cycles after each request, exercises the wait path.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

  typedef enum logic [1:0] {
    DUTY_16 = 2'b00,
    DUTY_24 = 2'b01,
    DUTY_32 = 2'b10,
    DUTY_48 = 2'b11
  } duty_e;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_REQ,
    BS_WAIT,
    BS_CLK
  } bs_state_e;

  typedef enum logic [1:0] {
    RC_FRAME,
    RC_SHIFT,
    RC_LOAD
  } rc_state_e;

  function automatic int unsigned rows_of(duty_e d);
    case (d)
      DUTY_16: return 16;
      DUTY_24: return 24;
      DUTY_32: return 32;
      default: return 48;
    endcase
  endfunction

endpackage

// File: rtl/lcdscan_bitseq.sv
module lcdscan_bitseq
  import lcdscan_pkg::*;
#(
  parameter int unsigned BITS_PER_ROW = 400,
  localparam int unsigned COL_W = (BITS_PER_ROW > 1) ? $clog2(BITS_PER_ROW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pix_vld_i,
  input  logic             pix_dat_i,
  output logic             pix_req_o,
  output logic [COL_W-1:0] pix_col_o,
  output logic             sdata_o,
  output logic             sclk_o,
  output logic             done_o
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(BITS_PER_ROW - 1);

  bs_state_e        st_q, st_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             col_en;
  logic             sdata_q;
  logic             sdata_en;
  logic             col_last;

  assign col_last = (col_q == LAST_COL);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    col_d    = col_q;
    col_en   = 1'b0;
    sdata_en = 1'b0;
    case (st_q)
      BS_IDLE: begin
        if (start_i) begin
          st_d   = BS_REQ;
          col_d  = '0;
          col_en = 1'b1;
        end
      end
      BS_REQ: st_d = BS_WAIT;
      BS_WAIT: begin
        if (pix_vld_i) begin
          st_d     = BS_CLK;
          sdata_en = 1'b1;
        end
      end
      BS_CLK: begin
        if (col_last) begin
          st_d = BS_IDLE;
        end else begin
          st_d   = BS_REQ;
          col_d  = col_q + 1'b1;
          col_en = 1'b1;
        end
      end
      default: st_d = BS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BS_IDLE;
      col_q   <= '0;
      sdata_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (col_en)   col_q   <= col_d;
      if (sdata_en) sdata_q <= pix_dat_i;
    end
  end

  assign pix_req_o = (st_q == BS_REQ);
  assign pix_col_o = col_q;
  assign sdata_o   = sdata_q;
  assign sclk_o    = (st_q == BS_CLK);
  assign done_o    = (st_q == BS_CLK) && col_last;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req_o |=> !pix_req_o); // R4
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (st_q == BS_IDLE)); // R4
  AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |=> !sclk_o); // R5
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_WAIT && !pix_vld_i) |=> (!sclk_o && !pix_req_o && $stable(sdata_o))); // R6

endmodule

// File: rtl/lcdscan_rowctl.sv
module lcdscan_rowctl
  import lcdscan_pkg::*;
#(
  parameter int unsigned NUM_COMS = 48,
  localparam int unsigned ROW_W = $clog2(NUM_COMS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  duty_e               duty_i,
  input  logic                done_i,
  output logic                start_o,
  output logic                load_o,
  output logic [ROW_W-1:0]    row_o,
  output logic [NUM_COMS-1:0] com_o,
  output logic                frame_o
);

  rc_state_e           st_q, st_d;
  logic [ROW_W-1:0]    row_q, row_d;
  logic                row_en;
  duty_e               duty_q;
  logic                duty_en;
  logic [NUM_COMS-1:0] com_q;
  logic [NUM_COMS-1:0] row_hot;
  logic                com_en;
  logic                frame_q;
  logic                frame_en;
  logic [ROW_W-1:0]    last_row;
  logic                row_last;

  assign last_row = ROW_W'(rows_of(duty_q) - 1);
  assign row_last = (row_q == last_row);

  // one-hot decode of the row being shifted
  for (genvar g = 0; g < NUM_COMS; g++) begin : g_dec
    assign row_hot[g] = (row_q == ROW_W'(g));
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    row_d    = row_q;
    row_en   = 1'b0;
    duty_en  = 1'b0;
    com_en   = 1'b0;
    frame_en = 1'b0;
    start_o  = 1'b0;
    case (st_q)
      RC_FRAME: begin
        duty_en = 1'b1;
        start_o = 1'b1;
        st_d    = RC_SHIFT;
      end
      RC_SHIFT: begin
        if (done_i) st_d = RC_LOAD;
      end
      RC_LOAD: begin
        com_en   = 1'b1;
        frame_en = (row_q == '0) && !com_q[0];
        row_en   = 1'b1;
        if (row_last) begin
          row_d = '0;
          st_d  = RC_FRAME;
        end else begin
          row_d   = row_q + 1'b1;
          start_o = 1'b1;
          st_d    = RC_SHIFT;
        end
      end
      default: st_d = RC_FRAME;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RC_FRAME;
      row_q   <= '0;
      duty_q  <= DUTY_48;
      com_q   <= NUM_COMS'(1);
      frame_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (row_en)   row_q   <= row_d;
      if (duty_en)  duty_q  <= duty_i;
      if (com_en)   com_q   <= row_hot;
      if (frame_en) frame_q <= !frame_q;
    end
  end

  assign load_o  = (st_q == RC_LOAD);
  assign row_o   = row_q;
  assign com_o   = com_q;
  assign frame_o = frame_q;

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != RC_FRAME) |-> (row_q <= last_row)); // R1
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != RC_FRAME) |=> $stable(duty_q)); // R2
  AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_q) == 1); // R3
  AST_DONE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (st_q == RC_SHIFT)); // R4
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o); // R7
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_q) |-> com_q[0]); // R8

endmodule

// File: rtl/lcd_row_scanner.sv
module lcd_row_scanner
  import lcdscan_pkg::*;
#(
  parameter int unsigned NUM_COMS     = 48,
  parameter int unsigned BITS_PER_ROW = 400,
  localparam int unsigned ROW_W = $clog2(NUM_COMS),
  localparam int unsigned COL_W = (BITS_PER_ROW > 1) ? $clog2(BITS_PER_ROW) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          duty_sel,
  input  logic                pix_vld,
  input  logic                pix_dat,
  output logic                pix_req,
  output logic [ROW_W-1:0]    pix_row,
  output logic [COL_W-1:0]    pix_col,
  output logic                seg_data,
  output logic                seg_clk,
  output logic                seg_load,
  output logic [NUM_COMS-1:0] com,
  output logic                frame_ac
);

  logic row_start;
  logic row_done;

  lcdscan_rowctl #(
    .NUM_COMS (NUM_COMS)
  ) u_rowctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .duty_i  (duty_e'(duty_sel)),
    .done_i  (row_done),
    .start_o (row_start),
    .load_o  (seg_load),
    .row_o   (pix_row),
    .com_o   (com),
    .frame_o (frame_ac)
  );

  lcdscan_bitseq #(
    .BITS_PER_ROW (BITS_PER_ROW)
  ) u_bitseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (row_start),
    .pix_vld_i (pix_vld),
    .pix_dat_i (pix_dat),
    .pix_req_o (pix_req),
    .pix_col_o (pix_col),
    .sdata_o   (seg_data),
    .sclk_o    (seg_clk),
    .done_o    (row_done)
  );

  AST_CLK_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_clk && seg_load)); // R7
  AST_COM_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(com) |-> $past(seg_load)); // R7

endmodule

// File: tb/sim_lcd_row_scanner.sv
`timescale 1ns/1ps
module sim_lcd_row_scanner;

  localparam int NCOM = 48;
  localparam int BITS = 10;
  localparam int RW   = $clog2(NCOM);
  localparam int CW   = $clog2(BITS);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      duty_sel;
  logic            pix_vld;
  logic            pix_dat;
  logic            pix_req;
  logic [RW-1:0]   pix_row;
  logic [CW-1:0]   pix_col;
  logic            seg_data;
  logic            seg_clk;
  logic            seg_load;
  logic [NCOM-1:0] com;
  logic            frame_ac;

  int lat;

  always #2 clk = ~clk;

  lcd_row_scanner #(.NUM_COMS(NCOM), .BITS_PER_ROW(BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .pix_vld(pix_vld), .pix_dat(pix_dat),
    .pix_req(pix_req), .pix_row(pix_row), .pix_col(pix_col), .seg_data(seg_data),
    .seg_clk(seg_clk), .seg_load(seg_load), .com(com), .frame_ac(frame_ac)
  );

  function automatic int rows_exp(logic [1:0] s);
    case (s)
      2'b00: return 16;
      2'b01: return 24;
      2'b10: return 32;
      default: return 48;
    endcase
  endfunction

  function automatic logic pat(int r, int c);
    return (((r * 7) + (c * 3) + (r * c)) % 5) < 2;
  endfunction

  // pixel source with programmable answer latency (>= 1)
  initial begin
    pix_vld = 1'b0;
    pix_dat = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && pix_req) begin
        int r;
        int c;
        r = int'(pix_row);
        c = int'(pix_col);
        repeat (lat) @(negedge clk);
        pix_vld = 1'b1;
        pix_dat = pat(r, c);
        @(negedge clk);
        pix_vld = 1'b0;
      end
    end
  end

  // ---------------- monitor (scoreboard) ----------------
  int m_checks = 0;
  int m_fails  = 0;
  int exp_row, bit_idx, disp_row, rows_cur, pend_row, rows_in_frame;
  int last_frame_rows = 0;
  int frame_cnt = 0;
  logic exp_frame, pend, pend_tog, prev_sclk, prev_load, prev_vld;

  task automatic mchk(input bit ok, input string req, input longint act, input longint exp);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_row = 0; bit_idx = 0; disp_row = 0; rows_in_frame = 0;
      rows_cur = rows_exp(duty_sel);
      exp_frame = 1'b0; pend = 1'b0; pend_tog = 1'b0;
      prev_sclk = 1'b0; prev_load = 1'b0; prev_vld = 1'b0;
    end else begin
      if (pend) begin
        disp_row = pend_row;
        if (pend_tog) begin
          exp_frame = ~exp_frame;
          frame_cnt++;
        end
        pend = 1'b0;
        mchk(com == (NCOM'(1) << disp_row), "R3 com one-hot at loaded row", longint'(com),
             longint'(NCOM'(1) << disp_row));
        mchk(frame_ac == exp_frame, "R8 frame_ac", longint'(frame_ac), longint'(exp_frame));
      end
      if (seg_clk) begin
        mchk(!prev_sclk, "R5 seg_clk single-cycle", 1, 0);
        mchk(prev_vld, "R6 seg_clk only after pix_vld", 0, 1);
        mchk(seg_data == pat(exp_row, bit_idx), "R5 seg_data bit", longint'(seg_data),
             longint'(pat(exp_row, bit_idx)));
        bit_idx++;
      end
      if (pix_req) begin
        mchk(int'(pix_row) == exp_row, "R4 pix_row", longint'(pix_row), exp_row);
        mchk(int'(pix_col) == bit_idx, "R4 pix_col", longint'(pix_col), bit_idx);
      end
      if (seg_load) begin
        mchk(!prev_load, "R7 seg_load single-cycle", 1, 0);
        mchk(!seg_clk, "R7 seg_clk low at load", longint'(seg_clk), 0);
        mchk(bit_idx == BITS, "R4 bits per row", bit_idx, BITS);
        pend = 1'b1;
        pend_row = exp_row;
        pend_tog = (exp_row == 0) && (disp_row != 0);
        if (pend_tog) begin
          last_frame_rows = rows_in_frame;
          rows_in_frame = 0;
        end
        rows_in_frame++;
        if (exp_row == rows_cur - 1) begin
          exp_row = 0;
          rows_cur = rows_exp(duty_sel);
        end else begin
          exp_row++;
        end
        bit_idx = 0;
      end
      prev_sclk = seg_clk;
      prev_load = seg_load;
      prev_vld  = pix_vld;
    end
  end

  // ---------------- directed scenarios ----------------
  int t_checks = 0;
  int t_fails  = 0;
  bit wd_fail  = 1'b0;

  task automatic tchk(input bit ok, input string req, input longint act, input longint exp);
    t_checks++;
    if (!ok) begin
      t_fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    int tot;
    int bad;
    tot = m_checks + t_checks + (wd_fail ? 1 : 0);
    bad = m_fails + t_fails + (wd_fail ? 1 : 0);
    $display("%0d/%0d checks passed", tot - bad, tot);
  endtask

  task automatic check_reset_outputs(input string tag);
    tchk(com == NCOM'(1), {tag, " com"}, longint'(com), 1);
    tchk(frame_ac == 1'b0, {tag, " frame_ac"}, longint'(frame_ac), 0);
    tchk(!seg_load && !seg_clk && !pix_req && !seg_data, {tag, " strobes low"},
         longint'({seg_load, seg_clk, pix_req, seg_data}), 0);
  endtask

  // wait until just after row 1 is loaded: far from any frame-start sample
  task automatic safe_point();
    do @(negedge clk); while (!(seg_load && pix_row == RW'(1)));
    @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frame_cnt + n;
    while (frame_cnt < target) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_outputs("R9 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    tchk(com == NCOM'(1) && frame_ac == 1'b0, "R9 after release", longint'(com), 1);
  endtask

  task automatic t_duty(input logic [1:0] sel, input int latency, input string tag);
    safe_point();
    lat = latency;
    duty_sel = sel;
    wait_frames(2);
    tchk(last_frame_rows == rows_exp(sel), tag, last_frame_rows, rows_exp(sel));
  endtask

  task automatic t_midchange();
    duty_sel = 2'b11;
    lat = 1;
    wait_frames(1);
    safe_point();
    duty_sel = 2'b00;
    wait_frames(1);
    tchk(last_frame_rows == 48, "R2 frame in progress keeps old duty", last_frame_rows, 48);
    wait_frames(1);
    tchk(last_frame_rows == 16, "R2 next frame uses new duty", last_frame_rows, 16);
  endtask

  task automatic t_reset_mid();
    duty_sel = 2'b01;
    do @(negedge clk); while (!(pix_req && pix_row == RW'(3)));
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_outputs("R9 mid-scan reset");
    @(negedge clk);
    rst_n = 1'b1;
    do @(negedge clk); while (!pix_req);
    tchk(pix_row == '0 && pix_col == '0, "R9 restart at row 0 col 0",
         longint'({pix_row, pix_col}), 0);
    wait_frames(2);
    tchk(last_frame_rows == 24, "R1 duty 24 after reset", last_frame_rows, 24);
  endtask

  initial begin
    rst_n    = 1'b0;
    duty_sel = 2'b11;
    lat      = 1;
    t_reset();
    t_duty(2'b00, 1, "R1 duty 16 rows");
    t_duty(2'b11, 2, "R1 duty 48 rows");
    t_duty(2'b01, 6, "R1 R6 duty 24 rows with slow source");
    t_duty(2'b10, 1, "R1 duty 32 rows");
    t_midchange();
    t_reset_mid();
    tchk(frame_cnt > 0, "R8 frames toggled", frame_cnt, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL R4 watchdog: scan did not complete act=hung exp=done");
    summary();
    $finish;
  end

endmodule